// File: doc/BRIEF.md
# Four-Channel Memory DMA Engine with Constant Fill

This block moves 32-bit words between memory regions on behalf of software. It has four independent channels. Each channel holds a source address, a destination address, two byte-count registers, a fill word, a spare timing word and a control word. Software programs a channel through a simple register write/read port and starts it by writing the go bit of the control word. The engine then runs beats on one shared word-wide memory master port that uses a valid/ready handshake.

A beat is either a copy or a fill. A copy beat reads one word from the source and then writes it to the destination. A fill beat writes the channel's fill word and does no read at all. Either address can be held fixed or stepped by four after every beat. When several channels are busy, they take turns one beat at a time. A channel that finishes can raise a sticky interrupt flag. A global enable bit gates all bus activity.

Register map (byte offsets):
- The global word is at 0x00. Bit 31 is the master enable. Bits 3:0 are the per-channel interrupt flags, and writing 1 to a flag clears it.
- Channel n starts at 0x04 + n*0x1C.
- Inside a channel block, the words follow in this order: source (+0x00), destination (+0x04), count A (+0x08), count B (+0x0C), timing (+0x10, stored only), fill (+0x14), control (+0x18).

Top module: `mc_dma_fill`

## Requirements
- R1: Register placement follows the map above. Every channel register reads back the value last written, including source and destination after a transfer has stepped their working copies.
- R2: With control bits 11, 13 and 14 clear, each beat reads the source word and writes it to the destination. Both addresses advance by 4 after each beat.
- R3: Control bit 11 set keeps the destination address fixed for the whole transfer.
- R4: Control bit 14 set with bit 13 clear keeps the source address fixed, so every destination word receives the same source word.
- R5: Control bits 13 and 14 both set make the channel issue no reads. It writes the fill register value to every destination word.
- R6: Writing count A sets control bit 28, and writing count B clears it. At start, the transfer length comes from count A when bit 28 is 1 and from count B when it is 0.
- R7: The byte count is rounded down to whole 4-byte words. A count below 4 completes with no bus beats.
- R8: Writing control bit 31 as 1 starts an idle channel. Bit 31 reads 1 while the channel is busy and is cleared by hardware at completion.
- R9: While global bit 31 is 0, no new bus beat starts, and busy channels stay busy until it is set again.
- R10: At completion with control bit 30 set, the channel's flag in global bits 3:0 is set. Writing 1 to a flag clears it. The irq output is 1 exactly when any flag is set. With bit 30 clear, no flag is set.
- R11: Busy channels are served round-robin, one beat per grant. A copy beat's read is followed directly by its write, and a presented request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| m_valid | output | 1 | Memory request valid |
| m_we | output | 1 | Memory request is a write |
| m_addr | output | 32 | Memory byte address |
| m_wdata | output | 32 | Memory write data |
| m_rdata | input | 32 | Memory read data, valid when a read is accepted |
| m_ready | input | 1 | Memory accepts the request |
| irq | output | 1 | OR of the channel interrupt flags |

## Verification
The transfer function is tried with several input patterns:
- A stepped copy, whose destination holds the source words in order.
- A fixed destination, where only the last source word survives.
- A fixed source, where one source word is repeated in every destination word.
- A fill, which writes a constant and makes no reads on the bus.

Count A and count B are given different values, so the destination span shows which one was used. An unaligned count and a zero count show the rounding. Two channels are started together, and the alternation of their write addresses shows beat-level round-robin. The memory model stalls ready on a fixed pattern, so the held requests are also exercised.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
  // register word index inside a channel block
  localparam logic [2:0] IX_SRC  = 3'd0;
  localparam logic [2:0] IX_DST  = 3'd1;
  localparam logic [2:0] IX_CNTA = 3'd2;
  localparam logic [2:0] IX_CNTB = 3'd3;
  localparam logic [2:0] IX_TIM  = 3'd4;
  localparam logic [2:0] IX_FILL = 3'd5;
  localparam logic [2:0] IX_CTRL = 3'd6;

  // control bit positions
  localparam int CB_FDST = 11;
  localparam int CB_FILL = 13;
  localparam int CB_FSRC = 14;
  localparam int CB_SELA = 28;
  localparam int CB_IE   = 30;
  localparam int CB_GO   = 31;

  localparam int CH_STRIDE = 28;
  localparam int CH_FIRST  = 4;

  typedef enum logic [1:0] {BUS_IDLE, BUS_RD, BUS_WR} bus_st_t;
endpackage

// File: rtl/dmaf_chan.sv
module dmaf_chan
  import dmaf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          beat_done,
  output logic          req,
  output logic [DW-1:0] src_addr,
  output logic [DW-1:0] dst_addr,
  output logic [DW-1:0] fill_val,
  output logic          fill_mode,
  output logic          done,
  output logic          irq_en
);
  localparam int WW = DW - 2;

  logic [DW-1:0] src_q, src_d, dst_q, dst_d, cnta_q, cnta_d, cntb_q, cntb_d;
  logic [DW-1:0] tim_q, tim_d, fil_q, fil_d, swk_q, swk_d, dwk_q, dwk_d;
  logic [WW-1:0] words_q, words_d;
  logic sela_q, sela_d, fdst_q, fdst_d, fflg_q, fflg_d, fsrc_q, fsrc_d;
  logic ie_q, ie_d, busy_q, busy_d;

  assign done      = busy_q && (words_q == '0);
  assign req       = busy_q && (words_q != '0);
  assign src_addr  = swk_q;
  assign dst_addr  = dwk_q;
  assign fill_val  = fil_q;
  assign fill_mode = fflg_q && fsrc_q;
  assign irq_en    = ie_q;

  // next-state
  always_comb begin
    src_d = src_q; dst_d = dst_q; cnta_d = cnta_q; cntb_d = cntb_q;
    tim_d = tim_q; fil_d = fil_q; swk_d = swk_q; dwk_d = dwk_q;
    words_d = words_q; sela_d = sela_q; fdst_d = fdst_q; fflg_d = fflg_q;
    fsrc_d = fsrc_q; ie_d = ie_q; busy_d = busy_q;
    if (done) busy_d = 1'b0;
    if (beat_done) begin
      words_d = words_q - 1'b1;
      if (!fsrc_q) swk_d = swk_q + DW'(4);
      if (!fdst_q) dwk_d = dwk_q + DW'(4);
    end
    if (wr_en) begin
      case (idx)
        IX_SRC:  begin src_d = wdata; swk_d = wdata; end
        IX_DST:  begin dst_d = wdata; dwk_d = wdata; end
        IX_CNTA: begin cnta_d = wdata; sela_d = 1'b1; end
        IX_CNTB: begin cntb_d = wdata; sela_d = 1'b0; end
        IX_TIM:  tim_d = wdata;
        IX_FILL: fil_d = wdata;
        IX_CTRL: if (!busy_q) begin
          fdst_d = wdata[CB_FDST];
          fflg_d = wdata[CB_FILL];
          fsrc_d = wdata[CB_FSRC];
          ie_d   = wdata[CB_IE];
          if (wdata[CB_GO]) begin
            busy_d  = 1'b1;
            words_d = sela_q ? cnta_q[DW-1:2] : cntb_q[DW-1:2];
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnta_q <= '0; cntb_q <= '0;
      tim_q <= '0; fil_q <= '0; swk_q <= '0; dwk_q <= '0;
      words_q <= '0; sela_q <= 1'b0; fdst_q <= 1'b0; fflg_q <= 1'b0;
      fsrc_q <= 1'b0; ie_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      src_q <= src_d; dst_q <= dst_d; cnta_q <= cnta_d; cntb_q <= cntb_d;
      tim_q <= tim_d; fil_q <= fil_d; swk_q <= swk_d; dwk_q <= dwk_d;
      words_q <= words_d; sela_q <= sela_d; fdst_q <= fdst_d; fflg_q <= fflg_d;
      fsrc_q <= fsrc_d; ie_q <= ie_d; busy_q <= busy_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (idx)
      IX_SRC:  rdata = src_q;
      IX_DST:  rdata = dst_q;
      IX_CNTA: rdata = cnta_q;
      IX_CNTB: rdata = cntb_q;
      IX_TIM:  rdata = tim_q;
      IX_FILL: rdata = fil_q;
      IX_CTRL: begin
        rdata[CB_GO]   = busy_q;
        rdata[CB_IE]   = ie_q;
        rdata[CB_SELA] = sela_q;
        rdata[CB_FSRC] = fsrc_q;
        rdata[CB_FILL] = fflg_q;
        rdata[CB_FDST] = fdst_q;
      end
      default: rdata = '0;
    endcase
  end

  // R8: a busy channel with nothing left drops busy on the next edge
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  // R3: fixed destination does not move on a beat
  p_fixed_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && fdst_q && !wr_en) |=> $stable(dwk_q));
endmodule

// File: rtl/dmaf_rr.sv
module dmaf_rr #(
  parameter int N  = 4,
  parameter int GW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  input  logic [GW-1:0] adv_idx,
  output logic [N-1:0]  grant,
  output logic [GW-1:0] grant_idx
);
  logic [GW-1:0] ptr_q, ptr_d;

  always_comb begin
    logic found;
    found     = 1'b0;
    grant     = '0;
    grant_idx = ptr_q;
    for (int i = 1; i <= N; i++) begin
      int k;
      k = (int'(ptr_q) + i) % N;
      if (!found && req[k]) begin
        found     = 1'b1;
        grant[k]  = 1'b1;
        grant_idx = GW'(k);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = adv_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= GW'(N - 1);
    else        ptr_q <= ptr_d;
  end

  // R11: at most one channel is granted at a time
  p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/mc_dma_fill.sv
module mc_dma_fill
  import dmaf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          m_valid,
  output logic          m_we,
  output logic [DW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_ready,
  output logic          irq
);
  localparam int GW = (NCH > 1) ? $clog2(NCH) : 1;

  // reset: asserted asynchronously, released on a clock edge
  logic rs1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs1_q <= 1'b0; srst_n <= 1'b0; end
    else        begin rs1_q <= 1'b1; srst_n <= rs1_q; end
  end

  logic [NCH-1:0] ch_hit, ch_req, ch_done, ch_ie, ch_fmode, beat, grant;
  logic [2:0]     ch_idx   [NCH];
  logic [DW-1:0]  ch_rd    [NCH];
  logic [DW-1:0]  ch_src   [NCH];
  logic [DW-1:0]  ch_dst   [NCH];
  logic [DW-1:0]  ch_fill  [NCH];
  logic [GW-1:0]  gidx, g_q, g_d;
  bus_st_t        st_q, st_d;
  logic [DW-1:0]  data_q, data_d;
  logic           men_q, men_d, beat_end;
  logic [NCH-1:0] flag_q, flag_d;
  logic           glb_hit;

  assign glb_hit = (reg_addr == '0);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(CH_FIRST + n * CH_STRIDE);
    assign ch_hit[n] = (reg_addr >= BASE) && (reg_addr < BASE + AW'(CH_STRIDE))
                       && (reg_addr[1:0] == 2'b00);
    assign ch_idx[n] = 3'((reg_addr - BASE) >> 2);
    assign beat[n]   = beat_end && (g_q == GW'(n));

    dmaf_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (srst_n),
      .wr_en     (reg_we && ch_hit[n]),
      .idx       (ch_idx[n]),
      .wdata     (reg_wdata),
      .rdata     (ch_rd[n]),
      .beat_done (beat[n]),
      .req       (ch_req[n]),
      .src_addr  (ch_src[n]),
      .dst_addr  (ch_dst[n]),
      .fill_val  (ch_fill[n]),
      .fill_mode (ch_fmode[n]),
      .done      (ch_done[n]),
      .irq_en    (ch_ie[n])
    );

    // R10: completion with interrupt enabled leaves the flag set
    p_flag_set_r10: assert property (@(posedge clk) disable iff (!srst_n)
      (ch_done[n] && ch_ie[n]) |=> flag_q[n]);
  end

  dmaf_rr #(.N(NCH), .GW(GW)) u_arb (
    .clk       (clk),
    .rst_n     (srst_n),
    .req       (ch_req),
    .adv       (beat_end),
    .adv_idx   (g_q),
    .grant     (grant),
    .grant_idx (gidx)
  );

  // register read
  always_comb begin
    reg_rdata = '0;
    if (glb_hit) begin
      reg_rdata[DW-1]    = men_q;
      reg_rdata[NCH-1:0] = flag_q;
    end
    for (int n = 0; n < NCH; n++)
      if (ch_hit[n]) reg_rdata = reg_rdata | ch_rd[n];
  end

  // global register next-state
  always_comb begin
    men_d  = men_q;
    flag_d = flag_q;
    if (reg_we && glb_hit) begin
      men_d  = reg_wdata[DW-1];
      flag_d = flag_q & ~reg_wdata[NCH-1:0];
    end
    flag_d = flag_d | (ch_done & ch_ie);
  end

  // bus sequencer next-state
  always_comb begin
    st_d     = st_q;
    g_d      = g_q;
    data_d   = data_q;
    beat_end = 1'b0;
    case (st_q)
      BUS_IDLE: if (men_q && (grant != '0)) begin
        g_d = gidx;
        if (ch_fmode[gidx]) begin
          data_d = ch_fill[gidx];
          st_d   = BUS_WR;
        end else begin
          st_d = BUS_RD;
        end
      end
      BUS_RD: if (m_ready) begin
        data_d = m_rdata;
        st_d   = BUS_WR;
      end
      BUS_WR: if (m_ready) begin
        beat_end = 1'b1;
        st_d     = BUS_IDLE;
      end
      default: st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= BUS_IDLE;
      g_q    <= '0;
      data_q <= '0;
      men_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      st_q   <= st_d;
      g_q    <= g_d;
      data_q <= data_d;
      men_q  <= men_d;
      flag_q <= flag_d;
    end
  end

  assign m_valid = (st_q != BUS_IDLE);
  assign m_we    = (st_q == BUS_WR);
  assign m_addr  = (st_q == BUS_RD) ? ch_src[g_q] : ch_dst[g_q];
  assign m_wdata = data_q;
  assign irq     = |flag_q;

  // R11: an accepted read is followed at once by the write of the same beat
  p_wr_after_rd_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (m_valid && !m_we && m_ready) |=> (m_valid && m_we));
  // R11: a stalled request keeps its address and direction
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_we)));
  // R9: a beat only begins after the master enable was seen set
  p_start_enabled_r9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(m_valid) |-> $past(men_q));
  // R5: a fill channel never presents a read
  p_fill_no_read_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (m_valid && !m_we) |-> !ch_fmode[g_q]);
endmodule

// File: tb/sim_mc_dma_fill.sv
module sim_mc_dma_fill;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GO = 32'h8000_0000, IE = 32'h4000_0000;
  localparam logic [31:0] FSRC = 32'h0000_4000, FILL = 32'h0000_2000, FDST = 32'h0000_0800;

  logic clk, rst_n, reg_we, m_valid, m_we, m_ready, irq;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, m_addr, m_wdata, m_rdata;
  logic [31:0] mem [0:255];
  logic [31:0] wlog [0:63];
  int wr_cnt, rd_cnt, checks, fails, cyc, rdy_cnt;
  bit finished;

  mc_dma_fill u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_valid(m_valid),
    .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ready(m_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(int i);
    return 32'hC0DE_0000 + 32'(i);
  endfunction

  assign m_rdata = mem[m_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 0; rd_cnt <= 0;
    end else if (m_valid && m_ready) begin
      if (m_we) begin
        mem[m_addr[9:2]] <= m_wdata;
        wlog[wr_cnt[5:0]] <= m_addr;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    m_ready <= (rdy_cnt % 3) != 2;
  end

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
        report();
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cb(int ch, int ix);
    return 8'(4 + ch * 28 + ix * 4);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(int ch, logic [31:0] s, logic [31:0] d, bit use_a,
                       logic [31:0] cnt, logic [31:0] ctl);
    wr(cb(ch, 0), s);
    wr(cb(ch, 1), d);
    wr(cb(ch, use_a ? 2 : 3), cnt);
    wr(cb(ch, 6), ctl | GO);
  endtask

  task automatic wait_idle(int ch);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(cb(ch, 6), v);
      if (!v[31]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R10 reset global", v, 0);
    rd(cb(0, 6), v); chk("R8 reset ctrl", v, 0);
    chk("R10 reset irq", {31'b0, irq}, 0);
    chk("R9 reset m_valid", {31'b0, m_valid}, 0);
  endtask

  task automatic t_copy();
    logic [31:0] v;
    setup(0, 32'h040, 32'h200, 1, 16, 0);
    wait_idle(0);
    for (int i = 0; i < 4; i++) chk("R2 copy word", mem[128 + i], pat(16 + i));
    chk("R2 beyond end", mem[132], pat(132));
    rd(cb(0, 0), v); chk("R1 src readback", v, 32'h040);
    rd(cb(0, 1), v); chk("R1 dst readback", v, 32'h200);
    rd(cb(0, 6), v); chk("R8 busy cleared", {31'b0, v[31]}, 0);
    wr(cb(0, 4), 32'h1234_5678);
    rd(cb(0, 4), v); chk("R1 timing stored", v, 32'h1234_5678);
  endtask

  task automatic t_fixed_dst();
    setup(1, 32'h060, 32'h240, 1, 12, FDST);
    wait_idle(1);
    chk("R3 fixed dst last", mem[144], pat(26));
    chk("R3 next untouched", mem[145], pat(145));
  endtask

  task automatic t_fixed_src();
    setup(2, 32'h080, 32'h260, 1, 12, FSRC);
    wait_idle(2);
    for (int i = 0; i < 3; i++) chk("R4 repeated src", mem[152 + i], pat(32));
  endtask

  task automatic t_fill();
    int r0, w0;
    logic [31:0] v;
    wr(cb(3, 5), 32'hF111_0007);
    r0 = rd_cnt; w0 = wr_cnt;
    setup(3, 32'h0F0, 32'h280, 1, 20, FSRC | FILL);
    wait_idle(3);
    for (int i = 0; i < 5; i++) chk("R5 fill word", mem[160 + i], 32'hF111_0007);
    chk("R5 no reads", 32'(rd_cnt - r0), 0);
    chk("R5 write count", 32'(wr_cnt - w0), 5);
    rd(cb(3, 5), v); chk("R1 fill readback", v, 32'hF111_0007);
  endtask

  task automatic t_count_sel();
    logic [31:0] v;
    wr(cb(0, 2), 40);
    rd(cb(0, 6), v); chk("R6 bit28 after A", {31'b0, v[28]}, 1);
    setup(0, 32'h0A0, 32'h2C0, 0, 8, 0);
    rd(cb(0, 6), v); chk("R6 bit28 after B", {31'b0, v[28]}, 0);
    wait_idle(0);
    chk("R6 word0", mem[176], pat(40));
    chk("R6 word1", mem[177], pat(41));
    chk("R6 count B length", mem[178], pat(178));
  endtask

  task automatic t_round();
    setup(1, 32'h0C0, 32'h2E0, 1, 10, 0);
    wait_idle(1);
    chk("R7 rounded word1", mem[185], pat(49));
    chk("R7 rounded stop", mem[186], pat(186));
  endtask

  task automatic t_zero();
    int w0;
    logic [31:0] v;
    w0 = wr_cnt;
    setup(2, 32'h0E0, 32'h3F0, 1, 3, IE);
    wait_idle(2);
    chk("R7 zero no beats", 32'(wr_cnt - w0), 0);
    rd(8'h00, v); chk("R10 flag set", v, 32'h8000_0004);
    chk("R10 irq high", {31'b0, irq}, 1);
    wr(8'h00, 32'h8000_0004);
    rd(8'h00, v); chk("R10 flag cleared", v, 32'h8000_0000);
    chk("R10 irq low", {31'b0, irq}, 0);
  endtask

  task automatic t_master();
    int w0;
    logic [31:0] v;
    wr(8'h00, 0);
    w0 = wr_cnt;
    setup(2, 32'h100, 32'h300, 1, 8, 0);
    repeat (30) @(negedge clk);
    chk("R9 no beats disabled", 32'(wr_cnt - w0), 0);
    rd(cb(2, 6), v); chk("R8 busy while held", {31'b0, v[31]}, 1);
    wr(8'h00, 32'h8000_0000);
    wait_idle(2);
    chk("R9 resumes", mem[193], pat(65));
  endtask

  task automatic t_no_ie();
    logic [31:0] v;
    setup(3, 32'h0F0, 32'h3F0, 1, 0, 0);
    wait_idle(3);
    rd(8'h00, v); chk("R10 no flag without ie", v, 32'h8000_0000);
  endtask

  task automatic t_rr();
    int w0;
    wr(8'h00, 0);
    w0 = wr_cnt;
    setup(0, 32'h140, 32'h340, 1, 12, 0);
    setup(1, 32'h180, 32'h380, 1, 12, 0);
    wr(8'h00, 32'h8000_0000);
    wait_idle(0); wait_idle(1);
    chk("R11 beat count", 32'(wr_cnt - w0), 6);
    for (int k = 1; k < 6; k++)
      chk("R11 alternation", {31'b0, wlog[6'(w0 + k)][7] ^ wlog[6'(w0 + k - 1)][7]}, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R11 ch0 data", mem[208 + i], pat(80 + i));
      chk("R11 ch1 data", mem[224 + i], pat(96 + i));
    end
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0; rdy_cnt = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; m_ready = 0;
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    wr(8'h00, 32'h8000_0000);
    t_copy();
    t_fixed_dst();
    t_fixed_src();
    t_fill();
    t_count_sel();
    t_round();
    t_zero();
    t_master();
    t_no_ie();
    t_rr();
    report();
  end
endmodule